// File: doc/BRIEF.md
# Configuration Packet Stream Interpreter

This block is the receiving end of a configuration port. It takes a stream of 32-bit words over a valid/ready handshake. At first it is unsynchronized: it accepts every word and discards it until the synchronization word arrives. Once synchronized, it reads each word as a packet header. A header names one internal 32-bit register and asks for a read, a write or nothing. Write packets are followed by their payload words, and each payload word is stored into the named register. A read packet sends the named register's value out on a 32-bit readback stream, once for each unit of its word count. The readback stream also uses valid/ready.

The register space is a small sparse set of slots: a status slot, an identification slot that returns a fixed parameter value, a command slot, and a number of plain storage slots. Writing the desynchronize code to the command slot returns the block to the unsynchronized state. The padding and bus-width detect patterns that come before the synchronization word need no special logic, because the hunt discards every word that is not the synchronization word.

Top module: `cfg_stream_target`

## Requirements
- R1: Synchronous active-high reset clears `outValid`, `isSynced` and `hdrError` and clears every stored register. After reset every slot reads back as zero, except the identification slot.
- R2: While `isSynced` is low, every word is accepted (`inReady` high) and discarded. Padding words such as 0xFFFFFFFF, 0x000000BB, 0x11220044 and 0x20000000 have no effect. Accepting 0xAA995566 raises `isSynced` in the next cycle.
- R3: When synchronized, a header has type bits [31:29] = 3'b001, opcode [28:27] (0 no-op, 1 read, 2 write, 3 treated as no-op), register address [26:13] and word count [10:0]. A no-op header, or any header with a word count of zero, has no effect. This includes 0x20000000.
- R4: A write header with word count N makes the next N accepted words payload. Each payload word is stored into the addressed register in turn, so the last one remains.
- R5: A read header with word count N pushes the addressed register's value N times onto the readback stream. `inReady` is low until the last value has been pushed.
- R6: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold steady and no further input is taken during the read.
- R7: Addresses 0x0–0xE, 0x10, 0x11, 0x16, 0x18 and 0x1F are implemented. The identification slot 0xC always reads the `ID_VALUE` parameter, and the status slot 0x7 always reads zero; writes to both are discarded. Unimplemented addresses read zero and discard writes.
- R8: The command slot 0x4 stores the last value written to it. Writing 0x0000000D to it makes `isSynced` fall in the next cycle. Any payload words left in that packet are then handled as hunt words.
- R9: A header whose type bits are not 3'b001 sets `hdrError`, which stays set until reset. The header has no other effect, and the block stays synchronized.
- R10: After a desynchronize, the synchronization word brings the block back, and stored register values are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word valid |
| inData | input | 32 | Input configuration word |
| inReady | output | 1 | Input word accepted when high together with inValid |
| outValid | output | 1 | Readback word valid |
| outData | output | 32 | Readback word |
| outReady | input | 1 | Consumer takes the readback word |
| isSynced | output | 1 | High while synchronized |
| hdrError | output | 1 | Sticky flag for a bad header type |

## Verification
The controller state shows at the ports within one cycle. A wrong sync state appears at once on `isSynced`. A missed or extra transition into the read state appears at once on `inReady` and on the readback stream. A wrong write enable or slot decode does not show until a later read of that slot. For that reason the bench writes a distinct value into every slot address, including the holes and the read-only slots, and reads them all back. The expected values come from the address list.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 14;
  localparam int COUNT_W = 11;
  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;
  localparam logic [WORD_W-1:0] CMD_DESYNC = 32'h0000000D;
  localparam logic [2:0] HDR_TYPE_ONE = 3'b001;
  localparam logic [1:0] OP_READ = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam int SLOT_CMD = 4;
  localparam int SLOT_STAT = 7;
  localparam int SLOT_ID = 12;

  typedef enum logic [1:0] {ST_HUNT, ST_HEADER, ST_WRITE, ST_READ} cfgState_e;

  typedef struct packed {
    logic wrEn;
    logic pushEn;
    logic [ADDR_W-1:0] regAddr;
  } cfgStrobe_t;

  function automatic logic slotExists(int s);
    return (s >= 0 && s <= 14) || s == 16 || s == 17 || s == 22 || s == 24 || s == 31;
  endfunction

  function automatic logic slotWritable(int s);
    return slotExists(s) && s != SLOT_STAT && s != SLOT_ID;
  endfunction
endpackage

// File: rtl/cfg_pkt_ctrl.sv
module cfg_pkt_ctrl
  import cfg_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  input  logic              outValid,
  input  logic              outReady,
  output logic              isSynced,
  output logic              hdrError,
  output cfgStrobe_t        strobe
);
  cfgState_e state;
  logic [COUNT_W-1:0] count;
  logic [ADDR_W-1:0] addrQ;
  logic accept;
  logic unusedRsvBits;

  assign unusedRsvBits = ^inData[12:11];
  assign inReady = (state != ST_READ);
  assign accept = inValid && inReady;
  assign isSynced = (state != ST_HUNT);

  always_comb begin
    strobe.wrEn = (state == ST_WRITE) && accept;
    strobe.pushEn = (state == ST_READ) && (!outValid || outReady);
    strobe.regAddr = addrQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      count <= '0;
      addrQ <= '0;
      hdrError <= 1'b0;
    end else begin
      case (state)
        ST_HUNT: if (accept && inData == SYNC_WORD) state <= ST_HEADER;
        ST_HEADER: if (accept) begin
          if (inData[31:29] != HDR_TYPE_ONE) begin
            hdrError <= 1'b1;
          end else begin
            addrQ <= inData[26:13];
            count <= inData[COUNT_W-1:0];
            if (inData[COUNT_W-1:0] != '0) begin
              if (inData[28:27] == OP_READ) state <= ST_READ;
              else if (inData[28:27] == OP_WRITE) state <= ST_WRITE;
            end
          end
        end
        ST_WRITE: if (accept) begin
          count <= count - 1'b1;
          if (addrQ == ADDR_W'(SLOT_CMD) && inData == CMD_DESYNC) state <= ST_HUNT;
          else if (count == 1) state <= ST_HEADER;
        end
        ST_READ: if (strobe.pushEn) begin
          count <= count - 1'b1;
          if (count == 1) state <= ST_HEADER;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_pkt_regs.sv
module cfg_pkt_regs
  import cfg_pkt_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1BAD0C0D,
  parameter int SLOT_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);
  localparam int NUM_SLOTS = 1 << SLOT_BITS;

  logic [WORD_W-1:0] slotVal [NUM_SLOTS];
  logic inRange;
  logic [SLOT_BITS-1:0] sel;
  logic [WORD_W-1:0] readVal;

  assign inRange = (strobe.regAddr[ADDR_W-1:SLOT_BITS] == '0);
  assign sel = strobe.regAddr[SLOT_BITS-1:0];
  assign readVal = inRange ? slotVal[sel] : '0;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    if (slotWritable(g)) begin : gStore
      logic [WORD_W-1:0] store;
      always_ff @(posedge clk) begin
        if (rst) store <= '0;
        else if (strobe.wrEn && inRange && sel == SLOT_BITS'(g)) store <= wrData;
      end
      assign slotVal[g] = store;
    end else if (g == SLOT_ID) begin : gId
      assign slotVal[g] = ID_VALUE;
    end else begin : gHole
      assign slotVal[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData <= '0;
    end else if (strobe.pushEn) begin
      outValid <= 1'b1;
      outData <= readVal;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_stream_target.sv
module cfg_stream_target
  import cfg_pkt_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1BAD0C0D,
  parameter int SLOT_BITS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] inData,
  output logic        inReady,
  output logic        outValid,
  output logic [31:0] outData,
  input  logic        outReady,
  output logic        isSynced,
  output logic        hdrError
);
  cfgStrobe_t strobe;

  cfg_pkt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .isSynced(isSynced),
    .hdrError(hdrError), .strobe(strobe)
  );

  cfg_pkt_regs #(.ID_VALUE(ID_VALUE), .SLOT_BITS(SLOT_BITS)) u_regs (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(inData), .outReady(outReady),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [31:0] inData,
  input logic        inReady,
  input logic        outValid,
  input logic [31:0] outData,
  input logic        outReady,
  input logic        isSynced,
  input logic        hdrError
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!outValid && !isSynced && !hdrError));

  assert_sync_only_on_word_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(isSynced) |-> $past(inValid && inReady && inData == 32'hAA995566));

  assert_hunt_takes_all_R2: assert property (@(posedge clk) disable iff (rst)
    !isSynced |-> inReady);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_no_out_unsynced_R5: assert property (@(posedge clk) disable iff (rst)
    (!isSynced && !outValid) |=> !outValid);

  assert_desync_on_word_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(isSynced) |-> $past(inValid && inReady && inData == 32'h0000000D));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    hdrError |=> hdrError);
endmodule

bind cfg_stream_target cfg_stream_checker u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady),
  .isSynced(isSynced), .hdrError(hdrError)
);

// File: tb/cfg_stream_target_tb.sv
module cfg_stream_target_tb;
  localparam logic [31:0] ID = 32'h1BAD0C0D;
  logic clk = 0, rst = 1, inValid = 0, outReady = 1;
  logic [31:0] inData = 0;
  logic inReady, outValid, isSynced, hdrError;
  logic [31:0] outData;
  int nRun = 0, nFail = 0;
  logic [31:0] rcv[$];

  always #5 clk = ~clk;

  cfg_stream_target #(.ID_VALUE(ID)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .isSynced(isSynced), .hdrError(hdrError)
  );

  always @(negedge clk) if (!rst && outValid && outReady) rcv.push_back(outData);

  function automatic bit impl(int a);
    return (a <= 14) || a == 16 || a == 17 || a == 22 || a == 24 || a == 31;
  endfunction
  function automatic logic [31:0] pat(int a);
    return 32'hA5000000 | (32'(a) << 8) | 32'(a + 1);
  endfunction
  function automatic logic [31:0] hdr(int op, int a, int n);
    return {3'b001, 2'(op), 14'(a), 2'b00, 11'(n)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [31:0] w);
    bit r;
    inValid = 1; inData = w;
    forever begin
      r = inReady;
      @(negedge clk);
      if (r) break;
    end
    inValid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readChk(int a, int n, logic [31:0] exp, string req);
    rcv.delete();
    put(hdr(1, a, n));
    idle(n + 4);
    chk(rcv.size() == n, req, 32'(rcv.size()), 32'(n));
    foreach (rcv[i]) chk(rcv[i] == exp, req, rcv[i], exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state
    chk(!outValid && !isSynced && !hdrError && inReady, "R1", {outValid, isSynced, hdrError}, 0);
    // R2 hunt: padding ignored
    put(32'hFFFFFFFF); put(32'h000000BB); put(32'h11220044); put(32'hFFFFFFFF);
    put(32'h20000000); put(hdr(1, 12, 1));
    idle(3);
    chk(!isSynced && rcv.size() == 0, "R2", {31'b0, isSynced}, 0);
    put(32'hAA995566);
    chk(isSynced, "R2", {31'b0, isSynced}, 1);
    // R3 no-op word
    put(32'h20000000); idle(3);
    chk(isSynced && rcv.size() == 0 && !hdrError, "R3", 32'(rcv.size()), 0);
    // R1 reset values of all slots
    for (int a = 0; a < 32; a++) readChk(a, 1, (a == 12) ? ID : 32'h0, "R1");
    // R7 write sweep over every slot address
    for (int a = 0; a < 32; a++) begin put(hdr(2, a, 1)); put(pat(a)); end
    for (int a = 0; a < 32; a++)
      readChk(a, 1, (a == 12) ? ID : (a == 7) ? 32'h0 : impl(a) ? pat(a) : 32'h0, "R7");
    // R7 out-of-range address discards write, reads zero
    put(hdr(2, 32 + 1, 1)); put(32'hDEADBEEF);
    readChk(33, 1, 32'h0, "R7");
    readChk(1, 1, pat(1), "R7");
    // R4 multi-word write, last wins; R5 multi read
    put(hdr(2, 1, 3)); put(32'h11111111); put(32'h22222222); put(32'h33333333);
    readChk(1, 4, 32'h33333333, "R4");
    readChk(16, 3, pat(16), "R5");
    // R6 stalled output
    rcv.delete();
    outReady = 0;
    put(hdr(1, 1, 3));
    idle(3);
    chk(outValid && outData == 32'h33333333, "R6", outData, 32'h33333333);
    chk(!inReady, "R5", {31'b0, inReady}, 0);
    outReady = 1;
    idle(8);
    chk(rcv.size() == 3 && inReady, "R6", 32'(rcv.size()), 3);
    // R3 zero word count write and read
    rcv.delete();
    put(hdr(2, 1, 0)); put(hdr(1, 1, 0)); put(hdr(0, 1, 5)); idle(3);
    chk(rcv.size() == 0, "R3", 32'(rcv.size()), 0);
    readChk(1, 1, 32'h33333333, "R3");
    // R9 bad header type
    put(32'h50000005); idle(1);
    chk(hdrError && isSynced, "R9", {hdrError, isSynced}, 2'b11);
    readChk(2, 1, pat(2), "R9");
    // R8 command slot
    put(hdr(2, 4, 1)); put(32'h7);
    readChk(4, 1, 32'h7, "R8");
    put(hdr(2, 4, 2)); put(32'hD);
    chk(!isSynced, "R8", {31'b0, isSynced}, 0);
    rcv.delete();
    put(hdr(1, 1, 1)); idle(4);
    chk(rcv.size() == 0 && !isSynced, "R8", 32'(rcv.size()), 0);
    chk(hdrError, "R9", {31'b0, hdrError}, 1);
    // R10 resync keeps values
    put(32'hAA995566);
    chk(isSynced, "R10", {31'b0, isSynced}, 1);
    readChk(1, 1, 32'h33333333, "R10");
    readChk(4, 1, 32'hD, "R10");
    // R1 reset clears sticky error and storage
    rst = 1; idle(2); rst = 0;
    chk(!hdrError && !isSynced && !outValid, "R1", {hdrError, isSynced}, 0);
    put(32'hAA995566);
    readChk(1, 1, 32'h0, "R1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule